// File: doc/BRIEF.md
# CAN Controller Configuration Guard

This block sits in front of a CAN protocol engine. It holds the configuration registers and enforces the rules that stop software from damaging bus traffic by mistake. Software reaches it through a single-cycle synchronous register port. Writes happen on a clock edge, and reads are combinational on the address.

Most configuration is locked while the controller is on-line. It opens only after software asks for initialization mode and the block confirms that it has gone off-line. The module enable can be written only once. The error counters can be read but not written. The transmit line is held recessive whenever the controller is off-line, powered down or disabled.

The block also makes the time-quantum strobe for the bit-timing logic. It divides a CAN clock, which is either the bus clock or the oscillator-tick stream, by a programmable ratio.

Top module: `can_cfg_guard`

## Requirements
- R1: After reset, every readable register reads 0, `tx_out` is 1 and `tq_en` is 0.
- R2: The enable is bit 7 of address 0x01. The first write to 0x01 after reset sets it from `wdata[7]`, and later writes leave it unchanged.
- R3: While the enable is 0, writes to address 0x00 are ignored, the acknowledge reads 0 and `tx_out` is 1.
- R4: The init request is bit 0 of address 0x00, and the acknowledge is bit 0 of address 0x01, which is read-only. The acknowledge reads 1 two clock edges after the edge that writes request=1, and reads 0 two edges after the edge that writes request=0, provided `bus_idle` is 1.
- R5: The acknowledge handshake only advances on edges where `bus_idle` is 1; otherwise the acknowledge holds its value.
- R6: Writes to the protected registers take effect only on an edge where the acknowledge is 1; at all other times they are dropped. The protected registers are:
  - bits 6..1 of 0x01;
  - 0x02 and 0x03 (bit timing);
  - 0x04 (acceptance control);
  - 0x08–0x0F (eight acceptance codes);
  - 0x10–0x17 (eight masks).
- R7: Reads return the current contents of every register in any mode. Unused addresses read 0.
- R8: Address 0x05 reads `rx_err_cnt` and address 0x06 reads `tx_err_cnt`, and writes to either address have no effect.
- R9: `tx_out` is 1 whenever the init request, the acknowledge or the power-down bit (bit 1 of 0x00) is set, or the enable is 0. Otherwise `tx_out` equals `tx_in`.
- R10: `tq_en` is a one-cycle pulse that fires once every N CAN-clock ticks, where N = `0x02[5:0]` + 1 (1..64).
- R11: Bit 6 of 0x01 selects the CAN clock. At 1, every bus-clock cycle is a tick; at 0, only cycles with `osc_tick`=1 are ticks.
- R12: While the acknowledge is 1, `tq_en` stays 0 and the divider is cleared. The first pulse comes N ticks after the acknowledge falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| bus_idle | input | 1 | Protocol engine reports an idle bus point |
| osc_tick | input | 1 | Oscillator clock enable, synchronous to `clk` |
| tx_in | input | 1 | Transmit bit from the protocol engine |
| tx_out | output | 1 | Transmit pin |
| rx_err_cnt | input | 8 | Receive error counter value |
| tx_err_cnt | input | 8 | Transmit error counter value |
| tq_en | output | 1 | Time-quantum strobe |

## Verification
The bench targets writes that land one edge before the acknowledge rises or falls. A design that sampled the lock one cycle early or late would accept or drop exactly those writes. It also checks divide ratios 1 and 64 and the oscillator-tick source: an off-by-one divider shows up as a wrong pulse spacing, and a design that ignored the clock select would show the bus-clock spacing. It further checks repeated enable writes and error-counter writes, which a design without the guards would let through to the read-back. Finally, it holds `bus_idle` low to catch a handshake that runs on a fixed delay.

// File: rtl/can_cfg_pkg.sv
package can_cfg_pkg;
  localparam int DW       = 8;
  localparam int AW       = 5;
  localparam int NFILT    = 8;
  localparam int PRESC_W  = 6;
  localparam int CFG1_W   = 6;

  localparam logic [AW-1:0] A_MODE   = 5'h00;
  localparam logic [AW-1:0] A_CFG1   = 5'h01;
  localparam logic [AW-1:0] A_TIME0  = 5'h02;
  localparam logic [AW-1:0] A_TIME1  = 5'h03;
  localparam logic [AW-1:0] A_FMODE  = 5'h04;
  localparam logic [AW-1:0] A_RXERR  = 5'h05;
  localparam logic [AW-1:0] A_TXERR  = 5'h06;
  localparam logic [AW-1:0] A_CODE0  = 5'h08;
  localparam logic [AW-1:0] A_MASK0  = 5'h10;

  typedef struct packed {
    logic pdn;
    logic req;
  } mode_bits_t;
endpackage

// File: rtl/cfg_mode_ctrl.sv
module cfg_mode_ctrl
  import can_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_mode,
  input  logic       wr_cfg1,
  input  logic [1:0] wmode,
  input  logic       wen,
  input  logic       bus_idle,
  output logic       en,
  output mode_bits_t mode,
  output logic       ack
);
  logic       en_q, en_d, lock_q, lock_d;
  mode_bits_t mode_q, mode_d;
  logic       stg_q, stg_d, ack_q, ack_d;

  always_comb begin
    en_d   = en_q;
    lock_d = lock_q;
    if (wr_cfg1 && !lock_q) begin
      en_d   = wen;
      lock_d = 1'b1;
    end
  end

  always_comb begin
    mode_d = mode_q;
    stg_d  = stg_q;
    ack_d  = ack_q;
    if (!en_q) begin
      mode_d = '0;
      stg_d  = 1'b0;
      ack_d  = 1'b0;
    end else begin
      if (wr_mode) mode_d = mode_bits_t'(wmode);
      if (bus_idle) begin
        stg_d = mode_q.req;
        ack_d = stg_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      lock_q <= 1'b0;
      mode_q <= '0;
      stg_q  <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      en_q   <= en_d;
      lock_q <= lock_d;
      mode_q <= mode_d;
      stg_q  <= stg_d;
      ack_q  <= ack_d;
    end
  end

  assign en   = en_q;
  assign mode = mode_q;
  assign ack  = ack_q;
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import can_cfg_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [AW-1:0]       addr,
  input  logic [DW-1:0]       wdata,
  input  logic                unlocked,
  output logic [CFG1_W-1:0]   cfg1,
  output logic [DW-1:0]       time0,
  output logic [DW-1:0]       time1,
  output logic [DW-1:0]       fmode,
  output logic [NFILT*DW-1:0] code_flat,
  output logic [NFILT*DW-1:0] mask_flat
);
  localparam int NPLAIN = 3;

  logic wok;
  assign wok = wr_en && unlocked;

  logic [CFG1_W-1:0] cfg1_q, cfg1_d;
  always_comb begin
    cfg1_d = cfg1_q;
    if (wok && addr == A_CFG1) cfg1_d = wdata[CFG1_W:1];
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg1_q <= '0;
    else        cfg1_q <= cfg1_d;
  end
  assign cfg1 = cfg1_q;

  logic [NPLAIN*DW-1:0] plain_q;
  generate
    for (genvar p = 0; p < NPLAIN; p++) begin : g_plain
      logic [DW-1:0] r_q, r_d;
      always_comb begin
        r_d = r_q;
        if (wok && addr == A_TIME0 + AW'(p)) r_d = wdata;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
      end
      assign plain_q[p*DW +: DW] = r_q;
    end

    for (genvar i = 0; i < NFILT; i++) begin : g_filt
      logic [DW-1:0] c_q, c_d, m_q, m_d;
      always_comb begin
        c_d = c_q;
        m_d = m_q;
        if (wok && addr == A_CODE0 + AW'(i)) c_d = wdata;
        if (wok && addr == A_MASK0 + AW'(i)) m_d = wdata;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          c_q <= '0;
          m_q <= '0;
        end else begin
          c_q <= c_d;
          m_q <= m_d;
        end
      end
      assign code_flat[i*DW +: DW] = c_q;
      assign mask_flat[i*DW +: DW] = m_q;
    end
  endgenerate

  assign time0 = plain_q[0*DW +: DW];
  assign time1 = plain_q[1*DW +: DW];
  assign fmode = plain_q[2*DW +: DW];
endmodule

// File: rtl/tq_prescaler.sv
module tq_prescaler #(
  parameter int PW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic [PW-1:0] ratio_m1,
  output logic          tq_en
);
  logic [PW-1:0] cnt_q, cnt_d;
  logic          tq_q, tq_d;

  always_comb begin
    cnt_d = cnt_q;
    tq_d  = 1'b0;
    if (!run) begin
      cnt_d = '0;
    end else if (tick) begin
      if (cnt_q == ratio_m1) begin
        cnt_d = '0;
        tq_d  = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tq_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tq_q  <= tq_d;
    end
  end

  assign tq_en = tq_q;
endmodule

// File: rtl/can_cfg_guard.sv
module can_cfg_guard
  import can_cfg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          bus_idle,
  input  logic          osc_tick,
  input  logic          tx_in,
  output logic          tx_out,
  input  logic [DW-1:0] rx_err_cnt,
  input  logic [DW-1:0] tx_err_cnt,
  output logic          tq_en
);
  logic                en, ack;
  mode_bits_t          mode;
  logic [CFG1_W-1:0]   cfg1;
  logic [DW-1:0]       time0, time1, fmode;
  logic [NFILT*DW-1:0] code_flat, mask_flat;
  logic                can_tick, run;

  cfg_mode_ctrl u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_mode  (wr_en && addr == A_MODE),
    .wr_cfg1  (wr_en && addr == A_CFG1),
    .wmode    (wdata[1:0]),
    .wen      (wdata[DW-1]),
    .bus_idle (bus_idle),
    .en       (en),
    .mode     (mode),
    .ack      (ack)
  );

  cfg_regfile u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .unlocked  (ack),
    .cfg1      (cfg1),
    .time0     (time0),
    .time1     (time1),
    .fmode     (fmode),
    .code_flat (code_flat),
    .mask_flat (mask_flat)
  );

  assign can_tick = cfg1[CFG1_W-1] ? 1'b1 : osc_tick;
  assign run      = en && !ack;

  tq_prescaler #(.PW(PRESC_W)) u_tq (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .tick     (can_tick),
    .ratio_m1 (time0[PRESC_W-1:0]),
    .tq_en    (tq_en)
  );

  assign tx_out = (!en || ack || mode.req || mode.pdn) ? 1'b1 : tx_in;

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_MODE:  rdata = {{(DW-2){1'b0}}, mode.pdn, mode.req};
      A_CFG1:  rdata = {en, cfg1, ack};
      A_TIME0: rdata = time0;
      A_TIME1: rdata = time1;
      A_FMODE: rdata = fmode;
      A_RXERR: rdata = rx_err_cnt;
      A_TXERR: rdata = tx_err_cnt;
      default: begin
        for (int i = 0; i < NFILT; i++) begin
          if (addr == A_CODE0 + AW'(i)) rdata = code_flat[i*DW +: DW];
          if (addr == A_MASK0 + AW'(i)) rdata = mask_flat[i*DW +: DW];
        end
      end
    endcase
  end
endmodule

// File: rtl/can_cfg_guard_chk.sv
module can_cfg_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       ack,
  input logic       req,
  input logic       pdn,
  input logic       bus_idle,
  input logic [7:0] time0,
  input logic       tq_en,
  input logic       tx_out
);
  AST_TX_RECESSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack || req || pdn || !en) |-> tx_out); // R9

  AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en) |-> en); // R2

  AST_LOCKED_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> $stable(time0)); // R6

  AST_ACK_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ack) || $fell(ack)) && en |-> $past(bus_idle)); // R5

  AST_TQ_QUIET_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    ack && $past(ack) |-> !tq_en); // R12

  AST_TQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tq_en && time0[5:0] != 6'd0 |=> !tq_en); // R10
endmodule

bind can_cfg_guard can_cfg_guard_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .ack      (ack),
  .req      (mode.req),
  .pdn      (mode.pdn),
  .bus_idle (bus_idle),
  .time0    (time0),
  .tq_en    (tq_en),
  .tx_out   (tx_out)
);

// File: tb/can_cfg_guard_tb.sv
`timescale 1ns/1ps
module can_cfg_guard_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [4:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       bus_idle, osc_tick, tx_in, tx_out, tq_en;
  logic [7:0] rx_err_cnt, tx_err_cnt;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  int osc_div = 3;
  int osc_cnt = 0;
  bit in_init = 0;
  logic [7:0] mdl [0:31];

  always #4 clk = ~clk;

  can_cfg_guard dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .bus_idle(bus_idle), .osc_tick(osc_tick), .tx_in(tx_in),
    .tx_out(tx_out), .rx_err_cnt(rx_err_cnt), .tx_err_cnt(tx_err_cnt), .tq_en(tq_en)
  );

  always @(negedge clk) begin
    osc_cnt  = (osc_cnt + 1) % osc_div;
    osc_tick = (osc_cnt == 0);
  end

  task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic peek(logic [4:0] a, output logic [7:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  function automatic bit is_prot(int a);
    return (a >= 1 && a <= 4) || (a >= 8 && a < 24);
  endfunction

  function automatic logic [7:0] exp_read(int a);
    if (a == 5) return rx_err_cnt;
    if (a == 6) return tx_err_cnt;
    if (a == 1) return {1'b1, mdl[1][6:1], in_init};
    return mdl[a];
  endfunction

  task automatic mdl_write(int a, logic [7:0] d);
    if (in_init && is_prot(a)) begin
      if (a == 1) mdl[1][6:1] = d[6:1];
      else        mdl[a] = d;
    end
  endtask

  task automatic enter_init();
    wr(5'h00, 8'h01);
    repeat (2) @(negedge clk);
    in_init = 1;
  endtask

  task automatic leave_init();
    wr(5'h00, 8'h00);
    repeat (2) @(negedge clk);
    in_init = 0;
  endtask

  task automatic gap_check(string rq, int exp);
    int t = 0;
    int first = -1;
    int second = -1;
    bit after_hi = 0;
    while (t < 2000 && second < 0) begin
      @(negedge clk);
      t++;
      if (after_hi) begin
        if (exp > 1) check({rq, " width"}, tq_en, 1'b0);
        after_hi = 0;
      end
      if (tq_en === 1'b1) begin
        if (first < 0) begin first = t; after_hi = 1; end
        else if (exp == 1 || t > first + 1) second = t;
      end
    end
    check({rq, " gap"}, second - first, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd2024));
    rst_n = 0; wr_en = 0; addr = 0; wdata = 0; bus_idle = 1;
    osc_tick = 0; tx_in = 0; rx_err_cnt = 8'h3c; tx_err_cnt = 8'hc3;
    for (int i = 0; i < 32; i++) mdl[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 24; a++) begin
      if (a == 5 || a == 6) continue;
      peek(a[4:0], v);
      check("R1 reg", v, 8'h00);
    end
    check("R1 tx", tx_out, 1'b1);
    check("R1 tq", tq_en, 1'b0);

    // R3 disabled: mode writes ignored
    wr(5'h00, 8'h01);
    repeat (3) @(negedge clk);
    peek(5'h00, v); check("R3 mode", v, 8'h00);
    peek(5'h01, v); check("R3 ack", v[0], 1'b0);
    tx_in = 0; #1; check("R3 tx", tx_out, 1'b1);

    // R8 error counters
    peek(5'h05, v); check("R8 rx", v, 8'h3c);
    wr(5'h06, 8'h11); peek(5'h06, v); check("R8 tx write", v, 8'hc3);
    wr(5'h05, 8'h22); peek(5'h05, v); check("R8 rx write", v, 8'h3c);

    // R2 enable write-once
    wr(5'h01, 8'h80);
    peek(5'h01, v); check("R2 set", v[7], 1'b1);
    wr(5'h01, 8'h00);
    peek(5'h01, v); check("R2 once", v[7], 1'b0 ^ 1'b1);

    // R6 protected write dropped while on-line
    wr(5'h02, 8'h55);
    peek(5'h02, v); check("R6 drop", v, 8'h00);

    // R9 tx follows when normal
    tx_in = 0; #1; check("R9 follow0", tx_out, 1'b0);
    tx_in = 1; #1; check("R9 follow1", tx_out, 1'b1);
    tx_in = 0;

    // R4 handshake timing, R9 immediate recessive
    wr(5'h00, 8'h01);
    #1; check("R9 req", tx_out, 1'b1);
    peek(5'h01, v); check("R4 ack e0", v[0], 1'b0);
    @(negedge clk); peek(5'h01, v); check("R4 ack e1", v[0], 1'b0);
    @(negedge clk); peek(5'h01, v); check("R4 ack e2", v[0], 1'b1);
    in_init = 1;
    wr(5'h00, 8'h00);
    #1; check("R9 ack holds tx", tx_out, 1'b1);
    @(negedge clk); peek(5'h01, v); check("R4 fall e1", v[0], 1'b1);
    @(negedge clk); peek(5'h01, v); check("R4 fall e2", v[0], 1'b0);
    in_init = 0;

    // R5 stall while bus busy
    bus_idle = 0;
    wr(5'h00, 8'h01);
    repeat (5) @(negedge clk);
    peek(5'h01, v); check("R5 stall", v[0], 1'b0);
    bus_idle = 1;
    @(negedge clk); peek(5'h01, v); check("R5 one", v[0], 1'b0);
    @(negedge clk); peek(5'h01, v); check("R5 two", v[0], 1'b1);
    in_init = 1;

    // R6/R7 random writes in and out of init
    for (int round = 0; round < 6; round++) begin
      for (int k = 0; k < 30; k++) begin
        int a;
        logic [7:0] d;
        a = 1 + int'($urandom_range(22));
        d = 8'($urandom());
        if (a == 1) d[7] = 1'b0;
        wr(a[4:0], d);
        mdl_write(a, d);
      end
      for (int a = 1; a < 24; a++) begin
        peek(a[4:0], v);
        check(in_init ? "R6 init rd" : "R7 online rd", v, exp_read(a));
      end
      if (in_init) leave_init(); else enter_init();
    end
    if (!in_init) enter_init();

    // R10 bus clock ratios, R11 select
    wr(5'h01, 8'h40); mdl[1][6:1] = 6'h20;
    wr(5'h02, 8'h03);
    leave_init();
    gap_check("R10 N4", 4);
    enter_init();
    wr(5'h02, 8'h00);
    leave_init();
    gap_check("R10 N1", 1);
    enter_init();
    wr(5'h02, 8'h3f);
    leave_init();
    gap_check("R10 N64", 64);
    enter_init();
    wr(5'h01, 8'h00);
    wr(5'h02, 8'h02);
    leave_init();
    gap_check("R11 osc", 9);

    // R12 quiet in init and first pulse position
    enter_init();
    wr(5'h01, 8'h40);
    wr(5'h02, 8'h04);
    begin
      int seen = 0;
      for (int i = 0; i < 20; i++) begin @(negedge clk); seen |= tq_en; end
      check("R12 quiet", seen, 0);
    end
    wr(5'h00, 8'h00);
    @(negedge clk);
    @(negedge clk);
    in_init = 0;
    begin
      int k = 0;
      while (tq_en !== 1'b1 && k < 100) begin @(negedge clk); k++; end
      check("R12 first", k, 5);
    end

    // R9 power-down
    wr(5'h00, 8'h02);
    tx_in = 0; #1; check("R9 pdn", tx_out, 1'b1);
    wr(5'h00, 8'h00);
    #1; check("R9 back", tx_out, 1'b0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule